// File: doc/BRIEF.md
# Comparator Offset Reference-Sliding Calibrator

This block removes the input offset of one comparator. It moves the comparator's reference input along the taps of a resistor ladder until the comparator's decision flips. The tap pointer is a one-hot chain of flip-flops. The chain moves one position each time the comparator reports the wrong polarity. In hardware this movement is triggered by the inverted decision, not by a counter run from a separate controller. When the comparator first decides high, the chain stops. The tap it rests on is the tap that cancels the offset.

The block has two modes, selected by `cal_mode`. In calibration mode, `cal_start` returns the reference to the bottom of the ladder and clears the settled flag. Each strobed low decision then advances the pointer by one tap. In conversion mode, the pointer is frozen and each strobed decision is passed to a registered data output. The block reports the one-hot tap select that drives the ladder switches, a binary copy of the tap index, and flags for the first and last tap. The analog comparator and the ladder are outside the block.

Top module: `offset_slide_cal`

## Requirements
- R1: After synchronous reset, `tap_sel` has only bit 0 set, `tap_idx` is 0, `at_begin` is 1, and `at_end`, `settled` and `conv_valid` are 0.
- R2: After reset, exactly one bit of `tap_sel` is high in every cycle.
- R3: With `cal_mode`=1, `cal_start`=1 moves the pointer to tap 0 and clears `settled` at the next clock edge. This takes priority over any decision presented in the same cycle.
- R4: With `cal_mode`=1, `cal_start`=0 and `settled`=0, a strobed decision of 0 (wrong polarity) moves the pointer up by exactly one tap at the next edge, unless it is on the last tap.
- R5: With `cal_mode`=1, `settled`=0 and no start, a strobed decision of 1 sets `settled` and leaves the pointer unchanged. While `settled` is 1, further decisions do not move the pointer until the next `cal_start`.
- R6: On the last tap (index TAPS-1), a further wrong-polarity decision leaves the pointer on the last tap. The pointer never wraps to tap 0.
- R7: `at_begin` is 1 exactly when the index is 0. `at_end` is 1 exactly when the index is TAPS-1.
- R8: `tap_idx` is the binary position of the set bit of `tap_sel`. Both change at the same clock edge.
- R9: With `cal_mode`=0, the pointer and `settled` hold their values, and `cal_start` is ignored.
- R10: With `cal_mode`=0, `conv_valid` equals `cmp_valid` one cycle later, and `conv_bit` equals `cmp_valid AND cmp_dec` one cycle later. With `cal_mode`=1, both outputs are 0 one cycle later.
- R11: A cycle with `cmp_valid`=0 and no start in calibration mode leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_mode | input | 1 | 1 = calibration, 0 = conversion |
| cal_start | input | 1 | Return the reference to tap 0 (calibration mode only) |
| cmp_valid | input | 1 | Strobe: a comparator decision is present |
| cmp_dec | input | 1 | Comparator decision, 1 = high |
| tap_sel | output | TAPS | One-hot ladder tap select |
| tap_idx | output | $clog2(TAPS) | Binary index of the selected tap |
| at_begin | output | 1 | Pointer is on the first tap |
| at_end | output | 1 | Pointer is on the last tap |
| settled | output | 1 | Comparator has flipped; calibration done |
| conv_valid | output | 1 | Registered conversion strobe |
| conv_bit | output | 1 | Registered conversion decision |

## Verification
The bound checker checks the cycle-level rules on every cycle: one-hot integrity, agreement between index and select, both flags, the single-step advance, saturation, settling, restart, freezing in conversion mode, and the pass-through. Only the bench scenarios can show whole calibration runs. These are runs that stop on each tap from the first to beyond the last. The bench also shows that decisions after settling are ignored, that a restart in the middle of a run works, that the settled state survives a trip through conversion mode, and that the reset state is correct.

// File: rtl/osc_pkg.sv
package osc_pkg;
  typedef enum logic {
    MODE_CONV = 1'b0,
    MODE_CAL  = 1'b1
  } osc_mode_e;

  function automatic int idx_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/osc_ctrl.sv
module osc_ctrl
  import osc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cal_mode,
  input  logic cal_start,
  input  logic cmp_valid,
  input  logic cmp_dec,
  input  logic at_last,
  output logic restart,
  output logic advance,
  output logic settled
);
  logic in_cal;
  logic decide;
  logic wrong_pol;

  assign in_cal    = (osc_mode_e'(cal_mode) == MODE_CAL);
  assign restart   = in_cal & cal_start;
  assign decide    = in_cal & cmp_valid & ~cal_start & ~settled;
  // inverted decision acts as the step trigger for the chain
  assign wrong_pol = ~cmp_dec;
  assign advance   = decide & wrong_pol & ~at_last;

  always_ff @(posedge clk) begin
    if (rst)                   settled <= 1'b0;
    else if (restart)          settled <= 1'b0;
    else if (decide & cmp_dec) settled <= 1'b1;
  end
endmodule

// File: rtl/osc_tap_chain.sv
module osc_tap_chain #(
  parameter int TAPS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            advance,
  output logic [TAPS-1:0] tap_d,
  output logic [TAPS-1:0] tap_q
);
  genvar i;
  generate
    for (i = 0; i < TAPS; i++) begin : g_cell
      if (i == 0) begin : g_head
        assign tap_d[i] = restart ? 1'b1 : (advance ? 1'b0 : tap_q[i]);
      end else if (i == TAPS-1) begin : g_tail
        assign tap_d[i] = restart ? 1'b0 : (advance ? (tap_q[i-1] | tap_q[i]) : tap_q[i]);
      end else begin : g_mid
        assign tap_d[i] = restart ? 1'b0 : (advance ? tap_q[i-1] : tap_q[i]);
      end
      always_ff @(posedge clk) begin
        if (rst) tap_q[i] <= (i == 0);
        else     tap_q[i] <= tap_d[i];
      end
    end
  endgenerate
endmodule

// File: rtl/osc_onehot_enc.sv
module osc_onehot_enc #(
  parameter int TAPS = 16,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TAPS-1:0] onehot_d,
  output logic [IW-1:0]   idx_q,
  output logic            first_q,
  output logic            last_q
);
  logic [IW-1:0] idx_d;

  always_comb begin
    idx_d = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (onehot_d[i]) idx_d = idx_d | IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      first_q <= 1'b1;
      last_q  <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      first_q <= onehot_d[0];
      last_q  <= onehot_d[TAPS-1];
    end
  end
endmodule

// File: rtl/osc_conv_path.sv
module osc_conv_path (
  input  logic clk,
  input  logic rst,
  input  logic cal_mode,
  input  logic cmp_valid,
  input  logic cmp_dec,
  output logic valid_q,
  output logic bit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      valid_q <= ~cal_mode & cmp_valid;
      bit_q   <= ~cal_mode & cmp_valid & cmp_dec;
    end
  end
endmodule

// File: rtl/offset_slide_cal.sv
module offset_slide_cal
  import osc_pkg::*;
#(
  parameter  int TAPS = 16,
  localparam int IW   = idx_width(TAPS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cal_mode,
  input  logic            cal_start,
  input  logic            cmp_valid,
  input  logic            cmp_dec,
  output logic [TAPS-1:0] tap_sel,
  output logic [IW-1:0]   tap_idx,
  output logic            at_begin,
  output logic            at_end,
  output logic            settled,
  output logic            conv_valid,
  output logic            conv_bit
);
  logic            restart;
  logic            advance;
  logic [TAPS-1:0] tap_d;

  osc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cal_mode  (cal_mode),
    .cal_start (cal_start),
    .cmp_valid (cmp_valid),
    .cmp_dec   (cmp_dec),
    .at_last   (tap_sel[TAPS-1]),
    .restart   (restart),
    .advance   (advance),
    .settled   (settled)
  );

  osc_tap_chain #(.TAPS(TAPS)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .advance (advance),
    .tap_d   (tap_d),
    .tap_q   (tap_sel)
  );

  osc_onehot_enc #(.TAPS(TAPS), .IW(IW)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .onehot_d (tap_d),
    .idx_q    (tap_idx),
    .first_q  (at_begin),
    .last_q   (at_end)
  );

  osc_conv_path u_conv (
    .clk       (clk),
    .rst       (rst),
    .cal_mode  (cal_mode),
    .cmp_valid (cmp_valid),
    .cmp_dec   (cmp_dec),
    .valid_q   (conv_valid),
    .bit_q     (conv_bit)
  );
endmodule

// File: rtl/offset_slide_cal_chk.sv
module offset_slide_cal_chk #(
  parameter int TAPS = 16,
  parameter int IW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cal_mode,
  input logic            cal_start,
  input logic            cmp_valid,
  input logic            cmp_dec,
  input logic [TAPS-1:0] tap_sel,
  input logic [IW-1:0]   tap_idx,
  input logic            at_begin,
  input logic            at_end,
  input logic            settled,
  input logic            conv_valid,
  input logic            conv_bit
);
  AST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_sel) == 1); // R2
  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
    tap_sel[tap_idx]); // R8
  AST_BEGIN_FLAG: assert property (@(posedge clk) disable iff (rst)
    at_begin == (tap_idx == '0)); // R7
  AST_END_FLAG: assert property (@(posedge clk) disable iff (rst)
    at_end == (tap_idx == IW'(TAPS-1))); // R7
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (cal_mode && cal_start) |=> (tap_idx == '0) && !settled); // R3
  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (cal_mode && !cal_start && cmp_valid && !cmp_dec && !settled && !at_end)
      |=> tap_idx == IW'($past(tap_idx) + 1'b1)); // R4
  AST_SETTLE: assert property (@(posedge clk) disable iff (rst)
    (cal_mode && !cal_start && cmp_valid && cmp_dec && !settled)
      |=> settled && $stable(tap_sel)); // R5
  AST_HOLD_SETTLED: assert property (@(posedge clk) disable iff (rst)
    (settled && !(cal_mode && cal_start)) |=> settled && $stable(tap_sel)); // R5
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (cal_mode && !cal_start && at_end) |=> at_end); // R6
  AST_CONV_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !cal_mode |=> $stable(tap_sel) && $stable(settled)); // R9
  AST_CONV_PASS: assert property (@(posedge clk) disable iff (rst)
    (!cal_mode && cmp_valid) |=> conv_valid && (conv_bit == $past(cmp_dec))); // R10
  AST_CAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    cal_mode |=> !conv_valid && !conv_bit); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cmp_valid && !(cal_mode && cal_start)) |=> $stable(tap_sel)); // R11
endmodule

bind offset_slide_cal offset_slide_cal_chk #(.TAPS(TAPS), .IW(IW)) u_chk (.*);

// File: tb/test_offset_slide_cal.sv
module test_offset_slide_cal;
  localparam int T  = 6;
  localparam int IW = $clog2(T);

  logic clk = 1'b0;
  logic rst, cal_mode, cal_start, cmp_valid, cmp_dec;
  logic [T-1:0]  tap_sel;
  logic [IW-1:0] tap_idx;
  logic at_begin, at_end, settled, conv_valid, conv_bit;

  int tests = 0, fails = 0;
  int e_idx = 0;
  logic e_set = 1'b0, e_cv = 1'b0, e_cb = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  offset_slide_cal #(.TAPS(T)) i_offset_slide_cal (
    .clk(clk), .rst(rst), .cal_mode(cal_mode), .cal_start(cal_start),
    .cmp_valid(cmp_valid), .cmp_dec(cmp_dec), .tap_sel(tap_sel),
    .tap_idx(tap_idx), .at_begin(at_begin), .at_end(at_end),
    .settled(settled), .conv_valid(conv_valid), .conv_bit(conv_bit));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(tap_idx == IW'(e_idx), {req, " idx R8"}, int'(tap_idx), e_idx);
    check(tap_sel == (T'(1) << e_idx), {req, " onehot R2"}, int'(tap_sel), 1 << e_idx);
    check(at_begin == (e_idx == 0), {req, " begin R7"}, int'(at_begin), int'(e_idx == 0));
    check(at_end == (e_idx == T-1), {req, " end R7"}, int'(at_end), int'(e_idx == T-1));
    check(settled == e_set, {req, " settled R5"}, int'(settled), int'(e_set));
    check(conv_valid == e_cv, {req, " conv_valid R10"}, int'(conv_valid), int'(e_cv));
    check(conv_bit == e_cb, {req, " conv_bit R10"}, int'(conv_bit), int'(e_cb));
  endtask

  task automatic cyc(input logic m, input logic s, input logic v, input logic d, input string req);
    @(negedge clk);
    cal_mode = m; cal_start = s; cmp_valid = v; cmp_dec = d;
    @(posedge clk);
    #1;
    if (m) begin
      if (s) begin e_idx = 0; e_set = 1'b0; end
      else if (v && !e_set) begin
        if (d) e_set = 1'b1;
        else if (e_idx < T-1) e_idx = e_idx + 1;
      end
    end
    e_cv = !m && v;
    e_cb = !m && v && d;
    check_all(req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cal_mode = 1'b0; cal_start = 1'b0; cmp_valid = 1'b0; cmp_dec = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    @(negedge clk); rst = 1'b0;

    // sweep: settle on every tap and beyond the last (R4, R5, R6)
    for (int k = 0; k <= T + 1; k++) begin
      cyc(1, 1, 0, 0, "R3 start");
      for (int j = 0; j < k; j++) cyc(1, 0, 1, 0, "R4 step");
      if (k >= T) cyc(1, 0, 1, 0, "R6 saturate");
      cyc(1, 0, 0, 0, "R11 idle");
      cyc(1, 0, 1, 1, "R5 flip");
      cyc(1, 0, 1, 0, "R5 ignore low");
      cyc(1, 0, 1, 1, "R5 ignore high");
    end

    // conversion mode: frozen, start ignored, pass-through (R9, R10)
    for (int p = 0; p < 8; p++) begin
      cyc(0, p[2], p[1], p[0], "R9 R10 conv");
    end
    cyc(1, 0, 1, 0, "R5 settled kept after conv");

    // restart in the middle of a run (R3)
    cyc(1, 1, 0, 0, "R3 start");
    cyc(1, 0, 1, 0, "R4 step");
    cyc(1, 0, 1, 0, "R4 step");
    cyc(1, 1, 1, 0, "R3 start beats decision");
    cyc(1, 0, 1, 0, "R4 step");
    cyc(0, 0, 1, 0, "R9 conv hold");
    cyc(1, 0, 1, 0, "R4 step");
    cyc(1, 0, 0, 1, "R11 idle");
    cyc(1, 0, 1, 1, "R5 flip");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule